// File: doc/BRIEF.md
# Slice-Grouped Line Change Timestamper

This block watches a wide bank of asynchronous input lines, grouped into slices of 32, and turns every change on an enabled line into a timestamped event record. Each slice compares its synchronised lines against the value it last reported. When an enabled bit differs, the slice latches the current count of a free-running 64-bit tick counter and holds the record until it is taken. A record carries the tick value, the slice number, the last reported 32-bit value of the slice and the new 32-bit value. Software finds the lines that changed by XOR of the two values. The line with global number `g` is bit `g % 32` of slice `g / 32`.

Records leave through a single valid/ready push port that feeds an external event FIFO. When several slices hold records, the lowest-numbered slice is sent first. A slice that is still waiting keeps its first timestamp and folds later changes into its pending value, so no edge is lost while the FIFO applies backpressure. The counter advances on every clock, one tick per cycle. At the intended 31.25 MHz tick a left shift by 5 gives nanoseconds. That conversion happens downstream.

Top module: `line_stamp_top`

## Requirements
- R1: After reset `rec_valid_o` is 0, the tick counter is 0, and the stored reported value of every slice is 0.
- R2: Input bit `lines_i[s*32+b]` is bit `b` of slice `s`, and mask bit `mask_i[s*32+b]` enables that same line. A record's `rec_slice_o` equals `s`, and its `rec_prev_o`/`rec_curr_o` bit `b` belongs to that line.
- R3: A line whose mask bit is 0 never causes a record. Its bit in `rec_curr_o` equals its bit in `rec_prev_o`.
- R4: `rec_prev_o` equals the `rec_curr_o` of the previous record sent for the same slice, or 0 if none was sent.
- R5: The tick counter increments on every clock edge after reset. A change that is first sampled at edge `k` after reset release gets `rec_ts_o = k + 1`. This reflects two synchroniser flops before comparison, and the record reaches the port one edge later.
- R6: Enabled lines of one slice that change on the same edge produce exactly one record, whose prev XOR curr has all of those bits set.
- R7: Among slices holding records, the lowest slice number is sent first, and at most one record is moved to the port per cycle.
- R8: While a slice's record waits, later changes on its enabled lines update its pending current value. Its timestamp stays the one latched at first detection.
- R9: While `glb_en_i` is 0 no new record is started. Changes that return to the reported value before re-enable produce no record. The tick counter keeps counting.
- R10: While `rec_valid_o` is 1 and `rec_ready_i` is 0, `rec_valid_o` and all record fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| glb_en_i | input | 1 | Global capture enable |
| lines_i | input | NUM_SLICES*32 | Asynchronous monitored lines |
| mask_i | input | NUM_SLICES*32 | Per-line enable mask |
| rec_valid_o | output | 1 | Record offered |
| rec_ready_i | input | 1 | Downstream accepts record |
| rec_ts_o | output | 64 | Tick count latched at detection |
| rec_slice_o | output | 8 | Slice number of record |
| rec_prev_o | output | 32 | Previously reported slice value |
| rec_curr_o | output | 32 | New slice value |

## Verification
The assertions check the following properties on every cycle:
- the port holds still under backpressure;
- the grant is one-hot and goes to the lowest pending slice;
- a pending slice is never dropped, and its timestamp stays frozen until it is granted;
- no capture starts while the global enable is off;
- the counter advances by one.

Only the directed scenarios can show the rest:
- the exact timestamp value relative to the input edge, through the synchroniser latency;
- the line-to-slice mapping;
- masking of individual bits;
- the prev/curr chaining between records;
- the merged value after backpressure.

// File: rtl/line_stamp_pkg.sv
package line_stamp_pkg;
  localparam int LINES_PER_SLICE = 32;
  localparam int TS_W            = 64;
  localparam int SLICE_ID_W      = 8;

  typedef struct packed {
    logic [TS_W-1:0]            ts;
    logic [SLICE_ID_W-1:0]      slice;
    logic [LINES_PER_SLICE-1:0] prev;
    logic [LINES_PER_SLICE-1:0] curr;
  } evt_rec_t;
endpackage

// File: rtl/line_stamp_sync.sv
module line_stamp_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/line_stamp_slice.sv
module line_stamp_slice
  import line_stamp_pkg::*;
#(
  parameter int SLICE_IDX = 0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       glb_en_i,
  input  logic [LINES_PER_SLICE-1:0] line_i,
  input  logic [LINES_PER_SLICE-1:0] mask_i,
  input  logic [TS_W-1:0]            ts_now_i,
  input  logic                       grant_i,
  output logic                       pend_o,
  output evt_rec_t                   rec_o
);
  logic                       pend_q;
  logic [TS_W-1:0]            ts_q;
  logic [LINES_PER_SLICE-1:0] prev_q, curr_q;
  logic [LINES_PER_SLICE-1:0] view_new, view_merge;
  logic                       detect;

  // disabled bits track the reference so they never show in the XOR
  assign view_new   = (line_i & mask_i) | (prev_q & ~mask_i);
  assign view_merge = (line_i & mask_i) | (curr_q & ~mask_i);
  assign detect     = glb_en_i && !pend_q && (view_new != prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ts_q   <= '0;
      prev_q <= '0;
      curr_q <= '0;
    end else if (grant_i) begin
      pend_q <= 1'b0;
      prev_q <= curr_q;
    end else if (detect) begin
      pend_q <= 1'b1;
      ts_q   <= ts_now_i;
      curr_q <= view_new;
    end else if (pend_q) begin
      curr_q <= view_merge;
    end
  end

  assign pend_o = pend_q;
  assign rec_o  = '{ts: ts_q, slice: SLICE_ID_W'(SLICE_IDX), prev: prev_q, curr: curr_q};

  p_pend_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !grant_i |=> pend_q);
  p_ts_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !grant_i |=> $stable(ts_q));
  p_gate_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_i && !pend_q |=> !pend_q);
  p_grant_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> pend_q);
endmodule

// File: rtl/line_stamp_arb.sv
module line_stamp_arb #(
  parameter int N = 4
) (
  input  logic         en_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  // lowest set bit wins
  assign gnt_o = en_i ? (req_i & (~req_i + N'(1))) : '0;

  always_comb begin
    a_onehot_r7: assert ($onehot0(gnt_o));
  end
endmodule

// File: rtl/line_stamp_top.sv
module line_stamp_top
  import line_stamp_pkg::*;
#(
  parameter int NUM_SLICES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  glb_en_i,
  input  logic [NUM_SLICES*LINES_PER_SLICE-1:0] lines_i,
  input  logic [NUM_SLICES*LINES_PER_SLICE-1:0] mask_i,
  output logic                                  rec_valid_o,
  input  logic                                  rec_ready_i,
  output logic [TS_W-1:0]                       rec_ts_o,
  output logic [SLICE_ID_W-1:0]                 rec_slice_o,
  output logic [LINES_PER_SLICE-1:0]            rec_prev_o,
  output logic [LINES_PER_SLICE-1:0]            rec_curr_o
);
  localparam int TOTAL_LINES = NUM_SLICES * LINES_PER_SLICE;

  logic [TS_W-1:0]        ts_q;
  logic [TOTAL_LINES-1:0] lines_s;
  logic [NUM_SLICES-1:0]  pend, gnt;
  evt_rec_t               slice_rec [NUM_SLICES];
  evt_rec_t               sel_rec, out_q;
  logic                   out_vld_q, take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_q <= '0;
    else         ts_q <= ts_q + TS_W'(1);
  end

  line_stamp_sync #(.W(TOTAL_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lines_i),
    .q_o   (lines_s)
  );

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    line_stamp_slice #(.SLICE_IDX(s)) u_slice (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .glb_en_i(glb_en_i),
      .line_i  (lines_s[s*LINES_PER_SLICE +: LINES_PER_SLICE]),
      .mask_i  (mask_i[s*LINES_PER_SLICE +: LINES_PER_SLICE]),
      .ts_now_i(ts_q),
      .grant_i (gnt[s]),
      .pend_o  (pend[s]),
      .rec_o   (slice_rec[s])
    );
  end

  assign take = !out_vld_q || rec_ready_i;

  line_stamp_arb #(.N(NUM_SLICES)) u_arb (
    .en_i (take),
    .req_i(pend),
    .gnt_o(gnt)
  );

  always_comb begin
    sel_rec = '0;
    for (int s = 0; s < NUM_SLICES; s++)
      if (gnt[s]) sel_rec = slice_rec[s];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_q <= 1'b0;
      out_q     <= '0;
    end else if (|gnt) begin
      out_vld_q <= 1'b1;
      out_q     <= sel_rec;
    end else if (rec_ready_i) begin
      out_vld_q <= 1'b0;
    end
  end

  assign rec_valid_o = out_vld_q;
  assign rec_ts_o    = out_q.ts;
  assign rec_slice_o = out_q.slice;
  assign rec_prev_o  = out_q.prev;
  assign rec_curr_o  = out_q.curr;

  p_hold_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(out_q));
  p_lowest_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt != '0) |-> (((gnt - NUM_SLICES'(1)) & pend) == '0));
  p_no_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && (pend != '0) |-> (gnt != '0));
  p_tick_runs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ts_q == $past(ts_q) + TS_W'(1));
endmodule

// File: tb/tb_line_stamp_top.sv
`timescale 1ns/1ps
module tb_line_stamp_top;
  localparam int NS = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           glb_en = 1'b1;
  logic [NS*32-1:0] lines = '0;
  logic [NS*32-1:0] mask = '1;
  logic           ready = 1'b0;
  logic           rec_valid;
  logic [63:0]    rec_ts;
  logic [7:0]     rec_slice;
  logic [31:0]    rec_prev, rec_curr;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  logic [31:0] mprev [NS];

  always #2.5 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  line_stamp_top #(.NUM_SLICES(NS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .glb_en_i(glb_en), .lines_i(lines), .mask_i(mask),
    .rec_valid_o(rec_valid), .rec_ready_i(ready), .rec_ts_o(rec_ts),
    .rec_slice_o(rec_slice), .rec_prev_o(rec_prev), .rec_curr_o(rec_curr)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_rec(string tag, longint ts, int sl, logic [31:0] curr);
    int w = 0;
    while (!rec_valid && w < 40) begin @(negedge clk); w++; end
    chk({tag, " valid"}, 64'(rec_valid), 64'd1);
    chk({tag, " ts"}, rec_ts, 64'(ts));
    chk({tag, " slice"}, 64'(rec_slice), 64'(sl));
    chk({tag, " prev"}, 64'(rec_prev), 64'(mprev[sl]));
    chk({tag, " curr"}, 64'(rec_curr), 64'(curr));
    mprev[sl] = curr;
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
  endtask

  task automatic expect_none(string tag, int n);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (rec_valid) seen = 1'b1; end
    chk({tag, " no record"}, 64'(seen), 64'd0);
  endtask

  task automatic t_reset();
    chk("R1 valid after reset", 64'(rec_valid), 64'd0);
  endtask

  task automatic t_single();
    int n = cyc;
    lines[2*32+6] = 1'b1;
    expect_rec("R2 R4 R5 single", n + 2, 2, 32'h40);
  endtask

  task automatic t_multi();
    int n = cyc;
    lines[3] = 1'b1; lines[17] = 1'b1; lines[31] = 1'b1;
    expect_rec("R6 multi", n + 2, 0, 32'h8002_0008);
    expect_none("R6 single record", 10);
  endtask

  task automatic t_mask();
    int n;
    mask[32] = 1'b0;
    lines[32] = 1'b1;
    expect_none("R3 masked line", 10);
    n = cyc;
    lines[33] = 1'b1;
    expect_rec("R3 masked bit unchanged", n + 2, 1, 32'h2);
  endtask

  task automatic t_order();
    int n = cyc;
    lines[96] = 1'b1; lines[1] = 1'b1;
    expect_rec("R7 first slice0", n + 2, 0, 32'h8002_000A);
    expect_rec("R7 then slice3", n + 2, 3, 32'h1);
  endtask

  task automatic t_merge();
    int n2;
    logic [127:0] snap;
    lines[37] = 1'b1;
    repeat (8) @(negedge clk);
    snap = {rec_ts, rec_slice, rec_prev, rec_curr[23:0]};
    n2 = cyc;
    lines[64] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 held under backpressure", 64'(snap != {rec_ts, rec_slice, rec_prev, rec_curr[23:0]}), 64'd0);
    lines[65] = 1'b1;
    repeat (6) @(negedge clk);
    expect_rec("R10 waiting slice1", n2 - 8 + 2, 1, 32'h22);
    expect_rec("R8 merged slice2", n2 + 2, 2, 32'h43);
  endtask

  task automatic t_global();
    int n;
    glb_en = 1'b0;
    lines[100] = 1'b1;
    repeat (4) @(negedge clk);
    lines[100] = 1'b0;
    expect_none("R9 disabled", 12);
    glb_en = 1'b1;
    expect_none("R9 reverted change", 8);
    n = cyc;
    lines[101] = 1'b1;
    expect_rec("R9 R5 counter kept running", n + 2, 3, 32'h21);
  endtask

  initial begin
    for (int s = 0; s < NS; s++) mprev[s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_mask();
    t_order();
    t_merge();
    t_global();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule